// File: doc/BRIEF.md
# Processor Sideband Signal Controller

This block sits in a chipset next to the processor. It drives the legacy sideband lines from a few I/O-mapped registers and from asynchronous event inputs. It produces five outputs: the address-bit-20 mask, the ignore-numeric-error handshake, an interrupt request for coprocessor errors aimed at the interrupt controller, a fixed-length processor init pulse, and the non-maskable interrupt.

Software reaches the block through a simple single-cycle I/O write/read port. The A20 control and the fast-init trigger sit at address 0x92. The two NMI source disables and the NMI source status flags sit at 0x61. A write of any data to 0xF0 requests the ignore-error handshake. A configuration register, 0xF4 by default, holds the coprocessor-error-reporting enable. All four event inputs are synchronized with two flops before use, and every output comes straight from a flop.

Top module: `cpu_sideband_ctl`

## Requirements
- R1: `a20m_n` is low when bit 1 of register 0x92 is set or when `a20_gate` is high. It is high when neither holds. The output follows within 4 clocks.
- R2: A read of 0x92 returns bits 1:0 as last written and zeros above them. A read of 0x61 returns bits 3:0 as last written. A read of the configuration register returns the enable in bit 0. Read data is valid the cycle after `io_rd`.
- R3: While the enable (bit 0 of the configuration register) is clear, `irq13` stays low and `ignne_n` stays high whatever `cp_err_n` does. Clearing the enable releases an asserted `ignne_n`.
- R4: While the enable is set and `cp_err_n` is low, `irq13` is high. It drops once `cp_err_n` returns high.
- R5: A write to 0xF0 made while the enable is set and `cp_err_n` is low drives `ignne_n` low. The same write made while `cp_err_n` is high leaves `ignne_n` high, even after `cp_err_n` later falls.
- R6: Once low, `ignne_n` stays low until `cp_err_n` returns high, and then it goes high. Writes to 0xF0 made while `cp_err_n` is high do not assert it. `ignne_n` is never low while `irq13` is low.
- R7: Writing 0x92 with bit 0 = 1 drives `init_n` low for exactly 16 clock cycles.
- R8: An init request made while `init_n` is already low is ignored: the pulse neither restarts nor lengthens. A request after the pulse ends starts a fresh 16-cycle pulse.
- R9: A falling edge on `bus_err_n` while bit 2 of 0x61 is clear sets status bit 7 of 0x61 and raises `nmi`. Both stay set after the input returns high.
- R10: A falling edge on `chan_chk_n` while bit 3 of 0x61 is clear sets status bit 6 of 0x61 and raises `nmi`.
- R11: Setting a source's disable bit clears that source's status flag, and `nmi` falls once no flag remains. Events on a disabled source are ignored. After a flag is cleared and re-enabled, `nmi` stays low until a new event arrives, which then gives a fresh rising edge.
- R12: After reset `a20m_n`, `ignne_n` and `init_n` are high, `nmi` and `irq13` are low, and the 0x92, 0x61 and configuration registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| a20_gate | input | 1 | Asynchronous A20 gate request, active high |
| cp_err_n | input | 1 | Asynchronous coprocessor error, active low |
| bus_err_n | input | 1 | Asynchronous bus error event, active low |
| chan_chk_n | input | 1 | Asynchronous channel-check event, active low |
| a20m_n | output | 1 | Address bit 20 mask to processor, active low |
| ignne_n | output | 1 | Ignore numeric error to processor, active low |
| init_n | output | 1 | Processor init pulse, active low |
| nmi | output | 1 | Non-maskable interrupt, active high |
| irq13 | output | 1 | Coprocessor error interrupt request, active high |

## Verification
The hardest case to reach is the ignore-error latch. It depends on the order of a port write against the level of an asynchronous input that lags by two synchronizer stages. The bench therefore holds `cp_err_n` in each state long enough to clear the synchronizer before issuing writes to 0xF0. It steps through every combination of enable and error level, then repeats writes after the error releases and after it returns. The init retrigger case is produced by raising the write strobe inside the per-cycle loop that counts the low cycles of `init_n`, so the second request lands four cycles into the pulse.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Default I/O addresses
  localparam logic [15:0] P92_ADDR_DEF  = 16'h0092;
  localparam logic [15:0] P61_ADDR_DEF  = 16'h0061;
  localparam logic [15:0] CERR_ADDR_DEF = 16'h00F0;
  localparam logic [15:0] CFG_ADDR_DEF  = 16'h00F4;

  // Register 0x92 field positions
  localparam int P92_INIT_BIT = 0;
  localparam int P92_A20_BIT  = 1;

  // Register 0x61 field positions
  localparam int P61_BUS_DIS  = 2;
  localparam int P61_CHK_DIS  = 3;
  localparam int P61_CHK_ST   = 6;
  localparam int P61_BUS_ST   = 7;

  // NMI source indices
  localparam int NMI_SRC_BUS = 0;
  localparam int NMI_SRC_CHK = 1;
  localparam int NMI_NSRC    = 2;

  // Synchronizer lane indices
  localparam int LANE_A20  = 0;
  localparam int LANE_CERR = 1;
  localparam int LANE_BUS  = 2;
  localparam int LANE_CHK  = 3;
  localparam int LANES     = 4;
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sb_init_pulse.sv
module sb_init_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      // Requests while active are dropped
      if (start) begin
        active <= 1'b1;
        cnt    <= CNT_W'(PULSE_LEN - 1);
      end
    end else if (cnt == '0) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sb_cerr_ctl.sv
module sb_cerr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic err_present,
  input  logic cerr_wr,
  output logic irq_req,
  output logic ign_act
);
  logic err_live;
  assign err_live = en & err_present;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      ign_act <= 1'b0;
    end else begin
      irq_req <= err_live;
      // Latched by a write only while the error is live; released with it
      ign_act <= err_live & (ign_act | cerr_wr);
    end
  end
endmodule

// File: rtl/sb_nmi_ctl.sv
module sb_nmi_ctl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_n,
  input  logic [NSRC-1:0] dis,
  output logic [NSRC-1:0] st,
  output logic            nmi
);
  logic [NSRC-1:0] prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= '1;
      st     <= '0;
      nmi    <= 1'b0;
    end else begin
      prev_n <= src_n;
      for (int i = 0; i < NSRC; i++) begin
        if (dis[i])                     st[i] <= 1'b0;
        else if (prev_n[i] && !src_n[i]) st[i] <= 1'b1;
      end
      nmi <= |st;
    end
  end
endmodule

// File: rtl/cpu_sideband_ctl.sv
module cpu_sideband_ctl
  import sb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN = 16,
  parameter logic [ADDR_W-1:0] P92_ADDR  = ADDR_W'(P92_ADDR_DEF),
  parameter logic [ADDR_W-1:0] P61_ADDR  = ADDR_W'(P61_ADDR_DEF),
  parameter logic [ADDR_W-1:0] CERR_ADDR = ADDR_W'(CERR_ADDR_DEF),
  parameter logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              a20_gate,
  input  logic              cp_err_n,
  input  logic              bus_err_n,
  input  logic              chan_chk_n,
  output logic              a20m_n,
  output logic              ignne_n,
  output logic              init_n,
  output logic              nmi,
  output logic              irq13
);
  localparam logic [LANES-1:0] SYNC_RST = 4'b1110;

  logic [1:0]          p92_q;
  logic [3:0]          p61_q;
  logic                cfg_en_q;
  logic [LANES-1:0]    raw_in, sync_q;
  logic [NMI_NSRC-1:0] nmi_st, nmi_src_n, nmi_dis;
  logic                wr92, wr61, wrcerr, wrcfg;
  logic                init_active, ign_act, irq_req;
  logic                unused_wdata;

  assign unused_wdata = ^io_wdata[7:4];

  assign wr92   = io_wr && (io_addr == P92_ADDR);
  assign wr61   = io_wr && (io_addr == P61_ADDR);
  assign wrcerr = io_wr && (io_addr == CERR_ADDR);
  assign wrcfg  = io_wr && (io_addr == CFG_ADDR);

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      p92_q    <= '0;
      p61_q    <= '0;
      cfg_en_q <= 1'b0;
    end else begin
      if (wr92)  p92_q    <= io_wdata[1:0];
      if (wr61)  p61_q    <= io_wdata[3:0];
      if (wrcfg) cfg_en_q <= io_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      if (io_addr == P92_ADDR)      io_rdata <= {6'b0, p92_q};
      else if (io_addr == P61_ADDR) io_rdata <= {nmi_st[NMI_SRC_BUS], nmi_st[NMI_SRC_CHK], 2'b0, p61_q};
      else if (io_addr == CFG_ADDR) io_rdata <= {7'b0, cfg_en_q};
      else                          io_rdata <= '0;
    end
  end

  // Input synchronizers
  always_comb begin
    raw_in            = '0;
    raw_in[LANE_A20]  = a20_gate;
    raw_in[LANE_CERR] = cp_err_n;
    raw_in[LANE_BUS]  = bus_err_n;
    raw_in[LANE_CHK]  = chan_chk_n;
  end

  sb_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
  );

  // A20 mask
  always_ff @(posedge clk) begin
    if (rst) a20m_n <= 1'b1;
    else     a20m_n <= ~(p92_q[P92_A20_BIT] | sync_q[LANE_A20]);
  end

  // Init pulse
  sb_init_pulse #(.PULSE_LEN(PULSE_LEN)) u_init (
    .clk(clk), .rst(rst), .start(wr92 && io_wdata[P92_INIT_BIT]), .active(init_active)
  );
  assign init_n = ~init_active;

  // Coprocessor error path
  sb_cerr_ctl u_cerr (
    .clk(clk), .rst(rst), .en(cfg_en_q), .err_present(~sync_q[LANE_CERR]),
    .cerr_wr(wrcerr), .irq_req(irq_req), .ign_act(ign_act)
  );
  assign irq13   = irq_req;
  assign ignne_n = ~ign_act;

  // NMI
  always_comb begin
    nmi_src_n              = '1;
    nmi_src_n[NMI_SRC_BUS] = sync_q[LANE_BUS];
    nmi_src_n[NMI_SRC_CHK] = sync_q[LANE_CHK];
    nmi_dis                = '0;
    nmi_dis[NMI_SRC_BUS]   = p61_q[P61_BUS_DIS];
    nmi_dis[NMI_SRC_CHK]   = p61_q[P61_CHK_DIS];
  end

  sb_nmi_ctl #(.NSRC(NMI_NSRC)) u_nmi (
    .clk(clk), .rst(rst), .src_n(nmi_src_n), .dis(nmi_dis), .st(nmi_st), .nmi(nmi)
  );
endmodule

// File: rtl/sb_sideband_chk.sv
module sb_sideband_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       a20m_n,
  input logic       ignne_n,
  input logic       irq13,
  input logic       init_n,
  input logic       nmi,
  input logic       en,
  input logic       a20_bit,
  input logic [1:0] st,
  input logic [1:0] dis
);
  localparam int LW = $clog2(PULSE_LEN + 2) + 1;
  localparam logic [LW-1:0] LMAX = '1;

  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst)          lowcnt <= '0;
    else if (!init_n) lowcnt <= (lowcnt == LMAX) ? lowcnt : lowcnt + 1'b1;
    else              lowcnt <= '0;
  end

  AST_A20_FROM_BIT: assert property (@(posedge clk) disable iff (rst) a20_bit |=> !a20m_n); // R1
  AST_CERR_OFF: assert property (@(posedge clk) disable iff (rst) !en |=> (!irq13 && ignne_n)); // R3
  AST_IGN_WITH_IRQ: assert property (@(posedge clk) disable iff (rst) !ignne_n |-> irq13); // R6
  AST_INIT_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(init_n) |-> (lowcnt == LW'(PULSE_LEN))); // R7
  AST_INIT_NO_STRETCH: assert property (@(posedge clk) disable iff (rst) lowcnt <= LW'(PULSE_LEN)); // R8
  AST_NMI_IDLE: assert property (@(posedge clk) disable iff (rst) (st == 2'b00) |=> !nmi); // R11
  AST_BUS_DIS: assert property (@(posedge clk) disable iff (rst) dis[0] |=> !st[0]); // R11
  AST_CHK_DIS: assert property (@(posedge clk) disable iff (rst) dis[1] |=> !st[1]); // R11
endmodule

bind cpu_sideband_ctl sb_sideband_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .a20m_n(a20m_n), .ignne_n(ignne_n), .irq13(irq13),
  .init_n(init_n), .nmi(nmi), .en(cfg_en_q), .a20_bit(p92_q[1]),
  .st(nmi_st), .dis(nmi_dis)
);

// File: tb/cpu_sideband_ctl_test.sv
module cpu_sideband_ctl_test;
  localparam logic [15:0] A92 = 16'h0092, A61 = 16'h0061, AF0 = 16'h00F0, ACFG = 16'h00F4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic a20_gate = 1'b0, cp_err_n = 1'b1, bus_err_n = 1'b1, chan_chk_n = 1'b1;
  logic a20m_n, ignne_n, init_n, nmi, irq13;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cpu_sideband_ctl uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .a20_gate(a20_gate), .cp_err_n(cp_err_n),
    .bus_err_n(bus_err_n), .chan_chk_n(chan_chk_n), .a20m_n(a20m_n), .ignne_n(ignne_n),
    .init_n(init_n), .nmi(nmi), .irq13(irq13)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic count_init(input bool_retrig, output int lows);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      if (!init_n) lows++;
      if (bool_retrig && i == 3) begin io_wr = 1'b1; io_addr = A92; io_wdata = 8'h01; end
      if (bool_retrig && i == 4) io_wr = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lows;

    // R12 reset state
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    check("R12", "a20m_n", a20m_n, 1);
    check("R12", "ignne_n", ignne_n, 1);
    check("R12", "init_n", init_n, 1);
    check("R12", "nmi", nmi, 0);
    check("R12", "irq13", irq13, 0);
    io_read(A92, rd);  check("R12", "rd92", rd, 0);
    io_read(A61, rd);  check("R12", "rd61", rd, 0);
    io_read(ACFG, rd); check("R12", "rdcfg", rd, 0);

    // R1 / R2 sweep over the A20 bit and the gate input
    for (int a = 0; a < 2; a++) begin
      for (int g = 0; g < 2; g++) begin
        io_write(A92, 8'(a << 1));
        a20_gate = g[0];
        wait_cyc(5);
        check("R1", "a20m_n", a20m_n, (a == 0 && g == 0) ? 1 : 0);
        io_read(A92, rd);
        check("R2", "rd92", rd, 32'(a << 1));
      end
    end
    a20_gate = 1'b0;
    io_write(A92, 8'h00);

    // R2 readback masks
    io_write(A92, 8'hFF); wait_cyc(20);
    io_read(A92, rd); check("R2", "rd92 mask", rd, 8'h03);
    io_write(A92, 8'h00);
    io_write(A61, 8'hFF);
    io_read(A61, rd); check("R2", "rd61 mask", rd, 8'h0F);
    io_write(A61, 8'h00);
    io_write(ACFG, 8'hFF);
    io_read(ACFG, rd); check("R2", "rdcfg mask", rd, 8'h01);

    // R7 init pulse length
    wait_cyc(20);
    io_write(A92, 8'h01);
    count_init(1'b0, lows);
    check("R7", "init low cycles", lows, 16);
    io_read(A92, rd); check("R2", "init bit readback", rd, 8'h01);

    // R8 retrigger during pulse is ignored
    io_write(A92, 8'h01);
    count_init(1'b1, lows);
    check("R8", "retrigger low cycles", lows, 16);
    io_write(A92, 8'h01);
    count_init(1'b0, lows);
    check("R8", "fresh pulse after end", lows, 16);
    io_write(A92, 8'h00);

    // R3 / R4 / R5 sweep over enable and error level
    for (int en = 0; en < 2; en++) begin
      for (int fe = 0; fe < 2; fe++) begin
        io_write(ACFG, 8'(en));
        cp_err_n = (fe == 0);
        wait_cyc(5);
        check(en ? "R4" : "R3", "irq13", irq13, (en == 1 && fe == 1) ? 1 : 0);
        check("R5", "ignne before write", ignne_n, 1);
        io_write(AF0, 8'h00);
        wait_cyc(2);
        check(en ? "R5" : "R3", "ignne after write", ignne_n, (en == 1 && fe == 1) ? 0 : 1);
        cp_err_n = 1'b1;
        wait_cyc(5);
        check("R6", "ignne after release", ignne_n, 1);
        check("R4", "irq13 after release", irq13, 0);
      end
    end

    // R5 write before the error is not remembered
    io_write(ACFG, 8'h01);
    io_write(AF0, 8'h5A);
    cp_err_n = 1'b0; wait_cyc(5);
    check("R5", "early write ignored", ignne_n, 1);

    // R6 hold and release
    io_write(AF0, 8'h00); wait_cyc(2);
    check("R6", "ignne asserted", ignne_n, 0);
    io_write(AF0, 8'h00); wait_cyc(10);
    check("R6", "ignne held", ignne_n, 0);
    cp_err_n = 1'b1; wait_cyc(5);
    check("R6", "ignne released", ignne_n, 1);
    io_write(AF0, 8'h00); wait_cyc(2);
    check("R6", "write without error", ignne_n, 1);
    cp_err_n = 1'b0; wait_cyc(5);
    check("R6", "no relatch on error return", ignne_n, 1);

    // R3 clearing enable releases ignne
    io_write(AF0, 8'h00); wait_cyc(2);
    check("R5", "ignne asserted again", ignne_n, 0);
    io_write(ACFG, 8'h00); wait_cyc(2);
    check("R3", "ignne after disable", ignne_n, 1);
    check("R3", "irq13 after disable", irq13, 0);
    cp_err_n = 1'b1; wait_cyc(5);

    // R9 / R10 / R11 NMI sweep
    for (int src = 0; src < 2; src++) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] disb, stb;
        disb = src ? 8'h08 : 8'h04;
        stb  = src ? 8'h40 : 8'h80;
        io_write(A61, d ? disb : 8'h00);
        wait_cyc(2);
        if (src == 0) bus_err_n = 1'b0; else chan_chk_n = 1'b0;
        wait_cyc(3);
        bus_err_n = 1'b1; chan_chk_n = 1'b1;
        wait_cyc(6);
        check(d ? "R11" : (src ? "R10" : "R9"), "nmi after event", nmi, d ? 0 : 1);
        io_read(A61, rd);
        check(d ? "R11" : (src ? "R10" : "R9"), "rd61 status", rd, d ? 32'(disb) : 32'(stb));
        if (d == 0) begin
          io_write(A61, disb); wait_cyc(4);
          check("R11", "nmi after disable", nmi, 0);
          io_read(A61, rd); check("R11", "status cleared", rd, 32'(disb));
          io_write(A61, 8'h00); wait_cyc(4);
          check("R11", "nmi stays low", nmi, 0);
          if (src == 0) bus_err_n = 1'b0; else chan_chk_n = 1'b0;
          wait_cyc(3);
          bus_err_n = 1'b1; chan_chk_n = 1'b1;
          wait_cyc(6);
          check("R11", "fresh nmi edge", nmi, 1);
          io_write(A61, 8'h0C); wait_cyc(4);
          check("R11", "nmi cleared", nmi, 0);
        end
      end
    end

    // R9 one source disabled, other still raises NMI
    io_write(A61, 8'h04); wait_cyc(2);
    chan_chk_n = 1'b0; wait_cyc(3); chan_chk_n = 1'b1; wait_cyc(6);
    check("R10", "nmi with bus source disabled", nmi, 1);
    io_read(A61, rd); check("R10", "rd61 mixed", rd, 8'h44);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule